// File: doc/BRIEF.md
# Packed Lane Shifter with Rounding and Saturation

This block shifts a 32-bit operand as a set of independent lanes, either four 8-bit lanes or two 16-bit lanes. Which lane width applies, and whether lanes hold signed or unsigned numbers, comes from the register numbers of the destination and source operands. The scheme is the same one the packed adder uses, so the same register index carries the same meaning in both blocks. Three shift kinds are offered: logical left, logical right and arithmetic right. The shift count comes either from an immediate or from the lowest lane of the second source register. In both cases one count applies to every lane.

A two-bit mode field picks the flavour. With mode 00 every shift truncates. With mode 01 a right shift rounds, and a left shift saturates at the lane's limits and raises an overflow flag. An operand combination the block cannot execute raises an illegal flag and yields zero. The result and the flags are registered and appear one clock after the request.

Top module: `simd_shift_round`

## Requirements
- R1: Register index ranges set the lane type. 2..7 is signed 8-bit, 8..15 unsigned 8-bit, 16..23 signed 16-bit and 24..29 unsigned 16-bit. The destination index selects the type. The rs2 index is ignored when `use_imm`=1.
- R2: The request is illegal when any of the following holds: an index in use lies outside 2..29, the indices in use disagree on lane width, `op`=11, or `mode` is 10 or 11. An illegal request gives `illegal`=1, `result`=0 and `ovf`=0.
- R3: The shift count is the low 3 bits (8-bit lanes) or the low 4 bits (16-bit lanes) of `imm` when `use_imm`=1. Otherwise it is the same low bits of `src_b`. All higher bits are ignored, and the count applies to every lane.
- R4: `op` 00 is logical left, 01 is logical right and 10 is arithmetic right. With `mode`=00 each lane shifts with truncation.
- R5: A right shift with `mode`=01 adds the last bit shifted out to the truncated lane result. A count of zero returns the operand unchanged.
- R6: A left shift with `mode`=01 clamps a lane when significant bits would be lost. In signed lanes the clamp goes to the lane maximum (non-negative input) or the lane minimum (negative input). In unsigned lanes it goes to all ones. `ovf`=1 when any lane clamps.
- R7: Lanes are processed independently, and no bit crosses a lane boundary.
- R8: Outputs register on the clock edge after `in_valid`=1, and `out_valid` follows `in_valid` one cycle later. `result` holds while `in_valid`=0. Reset clears `out_valid`, `result`, `ovf` and `illegal`.
- R9: `ovf` is 1 only for a left shift with `mode`=01. A plain left shift that loses bits leaves `ovf`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 2 | Shift kind: 00 left, 01 logical right, 10 arithmetic right |
| use_imm | input | 1 | Take the count from imm instead of src_b |
| imm | input | 4 | Immediate shift count |
| rd_idx | input | 5 | Destination register index |
| rs1_idx | input | 5 | First source register index |
| rs2_idx | input | 5 | Second source register index |
| src_a | input | 32 | Operand being shifted |
| src_b | input | 32 | Count source for the register form |
| mode | input | 2 | 00 truncate, 01 round or saturate |
| out_valid | output | 1 | Result strobe |
| result | output | 32 | Packed shifted lanes |
| ovf | output | 1 | Saturation occurred in some lane |
| illegal | output | 1 | Request could not be executed |

## Verification
A wrong lane-class decode shows up one cycle later in two ways: a legal request is flagged illegal, or a saturating left shift clamps to the wrong limit. The bank-boundary and mixed-index vectors expose both. A wrong count selection or rounding bit corrupts at least one lane on the very next result. Vectors with odd high bits in the count source, negative rounding and a zero count catch these. Per-lane vectors with different values in each lane reveal leakage between lanes or a flag raised by the wrong operation.

// File: rtl/simd_shift_pkg.sv
package simd_shift_pkg;

    localparam int PKG_DATA_W = 32;
    localparam int BYTE_W     = 8;
    localparam int HALF_W     = 16;
    localparam int BYTE_AW    = $clog2(BYTE_W);
    localparam int HALF_AW    = $clog2(HALF_W);
    localparam int IMM_W      = HALF_AW;
    localparam int REG_IDX_W  = 5;

    // Register index ranges that define lane type
    localparam int SB_LO = 2;
    localparam int SB_HI = 7;
    localparam int UB_LO = 8;
    localparam int UB_HI = 15;
    localparam int SH_LO = 16;
    localparam int SH_HI = 23;
    localparam int UH_LO = 24;
    localparam int UH_HI = 29;

    typedef enum logic [1:0] {
        OP_SLL = 2'b00,
        OP_SRL = 2'b01,
        OP_SRA = 2'b10,
        OP_RSV = 2'b11
    } shift_op_e;

    typedef enum logic [1:0] {
        MD_PLAIN = 2'b00,
        MD_ALT   = 2'b01,
        MD_RSV2  = 2'b10,
        MD_RSV3  = 2'b11
    } shift_mode_e;

    typedef enum logic [2:0] {
        LC_NONE  = 3'd0,
        LC_SBYTE = 3'd1,
        LC_UBYTE = 3'd2,
        LC_SHALF = 3'd3,
        LC_UHALF = 3'd4
    } lane_class_e;

    typedef struct packed {
        logic legal;
        logic half;
        logic signd;
        logic alt;
    } lane_cfg_t;

    function automatic lane_class_e classify(input logic [REG_IDX_W-1:0] idx);
        int unsigned v;
        v = int'(idx);
        if (v >= SB_LO && v <= SB_HI)      return LC_SBYTE;
        else if (v >= UB_LO && v <= UB_HI) return LC_UBYTE;
        else if (v >= SH_LO && v <= SH_HI) return LC_SHALF;
        else if (v >= UH_LO && v <= UH_HI) return LC_UHALF;
        else                               return LC_NONE;
    endfunction

    function automatic logic is_half(input lane_class_e c);
        return (c == LC_SHALF) || (c == LC_UHALF);
    endfunction

    function automatic logic is_signed_class(input lane_class_e c);
        return (c == LC_SBYTE) || (c == LC_SHALF);
    endfunction

endpackage

// File: rtl/sh_bank_decode.sv
module sh_bank_decode
    import simd_shift_pkg::*;
(
    input  logic [REG_IDX_W-1:0] rd_idx,
    input  logic [REG_IDX_W-1:0] rs1_idx,
    input  logic [REG_IDX_W-1:0] rs2_idx,
    input  logic                 use_imm,
    input  logic [1:0]           op,
    input  logic [1:0]           mode,
    output lane_cfg_t            cfg
);

    lane_class_e c_rd, c_rs1, c_rs2;
    logic        idx_ok, width_ok, ctrl_ok;

    always_comb begin
        c_rd  = classify(rd_idx);
        c_rs1 = classify(rs1_idx);
        c_rs2 = classify(rs2_idx);

        idx_ok = (c_rd != LC_NONE) && (c_rs1 != LC_NONE) &&
                 (use_imm || (c_rs2 != LC_NONE));

        width_ok = (is_half(c_rd) == is_half(c_rs1)) &&
                   (use_imm || (is_half(c_rd) == is_half(c_rs2)));

        ctrl_ok = (shift_op_e'(op) != OP_RSV) && !mode[1];

        cfg.legal = idx_ok && width_ok && ctrl_ok;
        cfg.half  = is_half(c_rd);
        cfg.signd = is_signed_class(c_rd);
        cfg.alt   = (shift_mode_e'(mode) == MD_ALT);
    end

endmodule

// File: rtl/sh_lane_unit.sv
module sh_lane_unit
    import simd_shift_pkg::*;
#(
    parameter int W  = 8,
    localparam int AW = $clog2(W)
) (
    input  logic [W-1:0]  a,
    input  logic [AW-1:0] amt,
    input  shift_op_e     op,
    input  logic          alt,
    input  logic          signd,
    output logic [W-1:0]  y,
    output logic          sat
);

    logic [W-1:0]  sra_t, srl_t, sll_t;
    logic [W-1:0]  back_s, back_u;
    logic [W-1:0]  clamp;
    logic [AW-1:0] last_idx;
    logic          last_out;
    logic          lost;

    always_comb begin
        sra_t = W'($signed(a) >>> amt);
        srl_t = a >> amt;
        sll_t = a << amt;

        // bit that falls off the bottom for a right shift
        last_idx = amt - AW'(1);
        last_out = (amt != '0) ? a[last_idx] : 1'b0;

        // left shift loses significance when shifting back differs
        back_s = W'($signed(sll_t) >>> amt);
        back_u = sll_t >> amt;
        lost   = signd ? (back_s != a) : (back_u != a);

        if (signd)
            clamp = a[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        else
            clamp = {W{1'b1}};

        y   = '0;
        sat = 1'b0;
        unique case (op)
            OP_SRA:  y = alt ? (sra_t + W'(last_out)) : sra_t;
            OP_SRL:  y = alt ? (srl_t + W'(last_out)) : srl_t;
            OP_SLL: begin
                if (alt && lost) begin
                    y   = clamp;
                    sat = 1'b1;
                end else begin
                    y = sll_t;
                end
            end
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/simd_shift_round.sv
module simd_shift_round
    import simd_shift_pkg::*;
#(
    parameter int DATA_W = PKG_DATA_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [1:0]           op,
    input  logic                 use_imm,
    input  logic [IMM_W-1:0]     imm,
    input  logic [REG_IDX_W-1:0] rd_idx,
    input  logic [REG_IDX_W-1:0] rs1_idx,
    input  logic [REG_IDX_W-1:0] rs2_idx,
    input  logic [DATA_W-1:0]    src_a,
    input  logic [DATA_W-1:0]    src_b,
    input  logic [1:0]           mode,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    result,
    output logic                 ovf,
    output logic                 illegal
);

    localparam int NB = DATA_W / BYTE_W;
    localparam int NH = DATA_W / HALF_W;

    lane_cfg_t          cfg;
    logic [BYTE_AW-1:0] byte_amt;
    logic [HALF_AW-1:0] half_amt;
    logic               amt_zero;
    logic [DATA_W-1:0]  byte_res, half_res;
    logic [NB-1:0]      byte_sat;
    logic [NH-1:0]      half_sat;
    logic               unused_b;

    sh_bank_decode u_decode (
        .rd_idx  (rd_idx),
        .rs1_idx (rs1_idx),
        .rs2_idx (rs2_idx),
        .use_imm (use_imm),
        .op      (op),
        .mode    (mode),
        .cfg     (cfg)
    );

    // one count for every lane, from imm or the lowest lane of src_b
    always_comb begin
        byte_amt = use_imm ? imm[BYTE_AW-1:0] : src_b[BYTE_AW-1:0];
        half_amt = use_imm ? imm[HALF_AW-1:0] : src_b[HALF_AW-1:0];
        amt_zero = cfg.half ? (half_amt == '0) : (byte_amt == '0);
    end

    assign unused_b = ^src_b[DATA_W-1:HALF_AW];

    generate
        for (genvar i = 0; i < NB; i++) begin : g_byte
            sh_lane_unit #(.W(BYTE_W)) u_lane (
                .a     (src_a[i*BYTE_W +: BYTE_W]),
                .amt   (byte_amt),
                .op    (shift_op_e'(op)),
                .alt   (cfg.alt),
                .signd (cfg.signd),
                .y     (byte_res[i*BYTE_W +: BYTE_W]),
                .sat   (byte_sat[i])
            );
        end
        for (genvar j = 0; j < NH; j++) begin : g_half
            sh_lane_unit #(.W(HALF_W)) u_lane (
                .a     (src_a[j*HALF_W +: HALF_W]),
                .amt   (half_amt),
                .op    (shift_op_e'(op)),
                .alt   (cfg.alt),
                .signd (cfg.signd),
                .y     (half_res[j*HALF_W +: HALF_W]),
                .sat   (half_sat[j])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            ovf       <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                if (cfg.legal) begin
                    result <= cfg.half ? half_res : byte_res;
                    ovf    <= cfg.half ? (|half_sat) : (|byte_sat);
                end else begin
                    result <= '0;
                    ovf    <= 1'b0;
                end
                illegal <= !cfg.legal;
            end
        end
    end

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (out_valid && illegal) |-> (result == '0 && !ovf)); // R2

    AST_OVF_ONLY_SAT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ovf) |-> $past(op == 2'b00 && mode == 2'b01)); // R9

    AST_ZERO_AMT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !illegal && $past(amt_zero)) |-> (result == $past(src_a))); // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result)); // R8

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(ovf && illegal)); // R2

endmodule

// File: tb/tb_simd_shift_round.sv
module tb_simd_shift_round;

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  op;
        logic        use_imm;
        logic [3:0]  imm;
        logic [4:0]  rd;
        logic [4:0]  rs1;
        logic [4:0]  rs2;
        logic [31:0] a;
        logic [31:0] b;
        logic [1:0]  mode;
        logic [31:0] exp;
        logic        eovf;
        logic        eill;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t TBL [NV] = '{
        // req op    imm   idx         rd     rs1    rs2     a             b             mode   exp         ovf   ill
        '{4'd4, 2'b10, 1'b1, 4'd1, 5'd2,  5'd3,  5'd31, 32'h807FF102, 32'h0,        2'b00, 32'hC03FF801, 1'b0, 1'b0}, // R4 R1
        '{4'd4, 2'b01, 1'b1, 4'd1, 5'd8,  5'd9,  5'd10, 32'h807FF102, 32'h0,        2'b00, 32'h403F7801, 1'b0, 1'b0}, // R4
        '{4'd3, 2'b00, 1'b0, 4'd0, 5'd16, 5'd17, 5'd18, 32'h12348001, 32'hABCD0004, 2'b00, 32'h23400010, 1'b0, 1'b0}, // R3
        '{4'd5, 2'b10, 1'b1, 4'd4, 5'd16, 5'd20, 5'd0,  32'h0018FFE8, 32'h0,        2'b01, 32'h0002FFFF, 1'b0, 1'b0}, // R5
        '{4'd5, 2'b01, 1'b1, 4'd2, 5'd8,  5'd12, 5'd0,  32'h0306FF01, 32'h0,        2'b01, 32'h01024000, 1'b0, 1'b0}, // R5
        '{4'd5, 2'b10, 1'b1, 4'd0, 5'd2,  5'd2,  5'd0,  32'hDEADBEEF, 32'h0,        2'b01, 32'hDEADBEEF, 1'b0, 1'b0}, // R5
        '{4'd6, 2'b00, 1'b0, 4'd0, 5'd2,  5'd3,  5'd4,  32'h10F00FE0, 32'h00000003, 2'b01, 32'h7F807880, 1'b1, 1'b0}, // R6
        '{4'd6, 2'b00, 1'b1, 4'd4, 5'd24, 5'd25, 5'd0,  32'h0FFF1000, 32'h0,        2'b01, 32'hFFF0FFFF, 1'b1, 1'b0}, // R6
        '{4'd6, 2'b00, 1'b1, 4'd1, 5'd16, 5'd16, 5'd0,  32'h3FFFC000, 32'h0,        2'b01, 32'h7FFE8000, 1'b0, 1'b0}, // R6
        '{4'd9, 2'b00, 1'b1, 4'd4, 5'd8,  5'd8,  5'd0,  32'hFF123456, 32'h0,        2'b00, 32'hF0204060, 1'b0, 1'b0}, // R9
        '{4'd3, 2'b01, 1'b0, 4'd0, 5'd8,  5'd9,  5'd10, 32'h80808080, 32'hFFFFFFF9, 2'b00, 32'h40404040, 1'b0, 1'b0}, // R3
        '{4'd3, 2'b10, 1'b1, 4'd15,5'd16, 5'd16, 5'd0,  32'h80007FFF, 32'h0,        2'b00, 32'hFFFF0000, 1'b0, 1'b0}, // R3
        '{4'd3, 2'b00, 1'b1, 4'd15,5'd8,  5'd8,  5'd0,  32'h01010101, 32'h0,        2'b00, 32'h80808080, 1'b0, 1'b0}, // R3
        '{4'd2, 2'b00, 1'b1, 4'd1, 5'd1,  5'd2,  5'd2,  32'h01010101, 32'h0,        2'b00, 32'h00000000, 1'b0, 1'b1}, // R2
        '{4'd2, 2'b00, 1'b1, 4'd1, 5'd2,  5'd16, 5'd2,  32'h01010101, 32'h0,        2'b00, 32'h00000000, 1'b0, 1'b1}, // R2
        '{4'd2, 2'b00, 1'b1, 4'd1, 5'd2,  5'd2,  5'd2,  32'h01010101, 32'h0,        2'b10, 32'h00000000, 1'b0, 1'b1}, // R2
        '{4'd2, 2'b11, 1'b1, 4'd1, 5'd2,  5'd2,  5'd2,  32'h01010101, 32'h0,        2'b00, 32'h00000000, 1'b0, 1'b1}, // R2
        '{4'd2, 2'b00, 1'b0, 4'd0, 5'd2,  5'd2,  5'd31, 32'h01010101, 32'h1,        2'b00, 32'h00000000, 1'b0, 1'b1}, // R2
        '{4'd1, 2'b01, 1'b1, 4'd1, 5'd30, 5'd30, 5'd0,  32'h01010101, 32'h0,        2'b00, 32'h00000000, 1'b0, 1'b1}, // R1
        '{4'd7, 2'b00, 1'b1, 4'd1, 5'd8,  5'd8,  5'd0,  32'h807F0100, 32'h0,        2'b01, 32'hFFFE0200, 1'b1, 1'b0}, // R7
        '{4'd1, 2'b00, 1'b1, 4'd1, 5'd2,  5'd2,  5'd0,  32'h807F0100, 32'h0,        2'b01, 32'h807F0200, 1'b1, 1'b0}, // R1
        '{4'd5, 2'b10, 1'b1, 4'd7, 5'd2,  5'd2,  5'd0,  32'hC040FF80, 32'h0,        2'b01, 32'h000100FF, 1'b0, 1'b0}  // R5
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  op = '0;
    logic        use_imm = 1'b0;
    logic [3:0]  imm = '0;
    logic [4:0]  rd_idx = '0, rs1_idx = '0, rs2_idx = '0;
    logic [31:0] src_a = '0, src_b = '0;
    logic [1:0]  mode = '0;
    logic        out_valid, ovf, illegal;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    simd_shift_round dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .use_imm(use_imm),
        .imm(imm), .rd_idx(rd_idx), .rs1_idx(rs1_idx), .rs2_idx(rs2_idx),
        .src_a(src_a), .src_b(src_b), .mode(mode),
        .out_valid(out_valid), .result(result), .ovf(ovf), .illegal(illegal)
    );

    task automatic check(input string tag, input logic [34:0] act, input logic [34:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got valid/ovf/ill/result %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        in_valid = 1'b1;
        op = v.op; use_imm = v.use_imm; imm = v.imm;
        rd_idx = v.rd; rs1_idx = v.rs1; rs2_idx = v.rs2;
        src_a = v.a; src_b = v.b; mode = v.mode;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        rst = 1'b0;
        check("R8 reset", {out_valid, ovf, illegal, result}, 35'h0);

        for (int k = 0; k < NV; k++) begin
            drive(TBL[k]);
            @(negedge clk);
            check($sformatf("R%0d vec %0d", TBL[k].req, k),
                  {out_valid, ovf, illegal, result},
                  {1'b1, TBL[k].eovf, TBL[k].eill, TBL[k].exp});
        end

        // R8 idle: valid drops, result holds last value
        in_valid = 1'b0;
        src_a = 32'h12345678;
        @(negedge clk);
        check("R8 idle hold", {out_valid, ovf, illegal, result},
              {1'b0, TBL[NV-1].eovf, TBL[NV-1].eill, TBL[NV-1].exp});

        // R7 halfword lanes independent under signed saturation
        drive('{4'd7, 2'b00, 1'b1, 4'd2, 5'd16, 5'd16, 5'd0, 32'h40000001,
                32'h0, 2'b01, 32'h0, 1'b0, 1'b0});
        @(negedge clk);
        check("R7 half lanes", {out_valid, ovf, illegal, result},
              {1'b1, 1'b1, 1'b0, 32'h7FFF0004});

        // R8 mid-run reset clears outputs
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        check("R8 reset mid run", {out_valid, ovf, illegal, result}, 35'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule